// File: doc/BRIEF.md
# Interrupt Controller With IRQ/FIQ Routing

This block collects 32 level-sensitive interrupt sources and presents them to a processor as two request lines: a normal interrupt (IRQ) and a fast interrupt (FIQ). Every source is the OR of a hardware request pin and a bit that software can set. A per-source enable mask gates each combined request, and a per-source select bit sends the request to one of the two outputs. Software can read the combined requests before masking, and it can read the masked requests that go to each output.

The block sits on a simple register bus with single-cycle accesses. Writes take effect at the next clock edge. Read data is combinational while the access is presented. The enable mask and the software requests each have one address that sets bits and another address that clears bits, so software never needs a read-modify-write. A protection bit, when set, makes the block refuse accesses that are flagged as user mode.

Top module: `irq_router`

## Requirements
- R1: After reset every register reads zero: all sources masked, all routed to IRQ, no software requests, protection off. Both outputs are low while the hardware requests are low.
- R2: Reading word offset 0x08 returns raw requests, the bitwise OR of hwReq and the software request register. Enable and select do not affect it.
- R3: Reading offset 0x00 returns raw & enable & ~select, the requests routed to IRQ. irqOut is high exactly when that value is non-zero.
- R4: Reading offset 0x04 returns raw & enable & select, the requests routed to FIQ. fiqOut is high exactly when that value is non-zero. No bit is set in both the IRQ status and the FIQ status.
- R5: A write to offset 0x10 ORs the written ones into the enable register. Enable bits that are already set stay set. Reading 0x10 returns the enable register.
- R6: A write to offset 0x14 clears each enable bit whose written bit is 1 and leaves the other enable bits unchanged. Reading 0x14 returns zero.
- R7: A write to offset 0x18 ORs the written ones into the software request register, and reading 0x18 returns that register. A write to 0x1C clears each software bit whose written bit is 1. Reading 0x1C returns zero.
- R8: Offset 0x0C is the select register and can be read and written. A bit value of 0 routes the source to IRQ and a bit value of 1 routes it to FIQ.
- R9: At offset 0x20, bit 0 is the protection flag and can be read and written. The other bits of 0x20 read as zero.
- R10: While protection is on, an access with busUser=1 has no effect on any register and reads back zero. An access with busUser=0 behaves normally. While protection is off, user accesses behave normally.
- R11: Offsets 0x24 to 0x3C read zero, and writes to them change no register. busAddr bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwReq | input | 32 | Level-sensitive hardware interrupt requests |
| busSel | input | 1 | Register access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busUser | input | 1 | Access issued from user mode |
| busAddr | input | 6 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while a read is presented |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
The status logic is swept over every source. For each source, the bench tries all 16 combinations of hardware request, software request, enable and select. This shows that hardware and software requests each reach the raw status independently, and that the mask and the route act on exactly one bit. Dense multi-bit patterns then check that no bit leaks into a neighbour and that set and clear accesses leave unwritten bits unchanged. Protection is tried in all four combinations of the flag and the mode bit. These runs separate a blocked write from a blocked read, and they show that privileged traffic is unaffected.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  typedef enum logic [3:0] {
    REG_IRQ_STAT  = 4'd0,
    REG_FIQ_STAT  = 4'd1,
    REG_RAW_STAT  = 4'd2,
    REG_ROUTE     = 4'd3,
    REG_EN_SET    = 4'd4,
    REG_EN_CLR    = 4'd5,
    REG_SOFT_SET  = 4'd6,
    REG_SOFT_CLR  = 4'd7,
    REG_PROT      = 4'd8,
    REG_NONE      = 4'd15
  } regIdx_e;

  typedef struct packed {
    logic    wrRoute;
    logic    wrEnSet;
    logic    wrEnClr;
    logic    wrSoftSet;
    logic    wrSoftClr;
    logic    wrProt;
    regIdx_e rdIdx;
  } busStrobe_t;

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic              busUser,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              protOn,
  output busStrobe_t        strobe
);

  localparam int WORD_W  = ADDR_W - 2;
  localparam int LAST_IX = 8;

  logic [WORD_W-1:0] wordIdx;
  regIdx_e           decIdx;
  logic              accessOk;
  logic              doWrite;

  assign wordIdx  = busAddr[ADDR_W-1:2];
  // user-mode accesses are refused while protection is on (R10)
  assign accessOk = busSel && !(protOn && busUser);
  assign doWrite  = accessOk && busWrite;

  always_comb begin
    if (int'(wordIdx) <= LAST_IX) decIdx = regIdx_e'(4'(wordIdx));
    else                          decIdx = REG_NONE;   // R11
  end

  always_comb begin
    strobe           = '0;
    strobe.wrRoute   = doWrite && (decIdx == REG_ROUTE);
    strobe.wrEnSet   = doWrite && (decIdx == REG_EN_SET);
    strobe.wrEnClr   = doWrite && (decIdx == REG_EN_CLR);
    strobe.wrSoftSet = doWrite && (decIdx == REG_SOFT_SET);
    strobe.wrSoftClr = doWrite && (decIdx == REG_SOFT_CLR);
    strobe.wrProt    = doWrite && (decIdx == REG_PROT);
    strobe.rdIdx     = (accessOk && !busWrite) ? decIdx : REG_NONE;
  end

  // at most one register written per access (R11)
  p_one_write_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.wrRoute, strobe.wrEnSet, strobe.wrEnClr,
              strobe.wrSoftSet, strobe.wrSoftClr, strobe.wrProt}));

  // a refused access produces no write strobe (R10)
  p_user_no_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (protOn && busUser) |->
      ($countones({strobe.wrRoute, strobe.wrEnSet, strobe.wrEnClr,
                   strobe.wrSoftSet, strobe.wrSoftClr, strobe.wrProt}) == 0));

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwReq,
  input  logic [DATA_W-1:0]  wData,
  input  busStrobe_t         strobe,
  output logic [DATA_W-1:0]  rData,
  output logic               irqOut,
  output logic               fiqOut,
  output logic               protOn
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] routeReg;
  logic [NUM_SRC-1:0] enReg;
  logic [NUM_SRC-1:0] softReg;
  logic               protReg;
  logic [NUM_SRC-1:0] wBits;
  logic [NUM_SRC-1:0] rawStat;
  logic [NUM_SRC-1:0] irqStat;
  logic [NUM_SRC-1:0] fiqStat;

  assign wBits  = wData[NUM_SRC-1:0];
  assign protOn = protReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      routeReg <= '0;
      enReg    <= '0;
      softReg  <= '0;
      protReg  <= 1'b0;
    end else begin
      if (strobe.wrRoute)   routeReg <= wBits;
      if (strobe.wrEnSet)   enReg    <= enReg | wBits;
      if (strobe.wrEnClr)   enReg    <= enReg & ~wBits;
      if (strobe.wrSoftSet) softReg  <= softReg | wBits;
      if (strobe.wrSoftClr) softReg  <= softReg & ~wBits;
      if (strobe.wrProt)    protReg  <= wData[0];
    end
  end

  // per-source combine, mask and route
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign rawStat[s] = hwReq[s] | softReg[s];
    assign irqStat[s] = rawStat[s] & enReg[s] & ~routeReg[s];
    assign fiqStat[s] = rawStat[s] & enReg[s] &  routeReg[s];
  end

  assign irqOut = |irqStat;
  assign fiqOut = |fiqStat;

  always_comb begin
    unique case (strobe.rdIdx)
      REG_IRQ_STAT: rData = {{PAD_W{1'b0}}, irqStat};
      REG_FIQ_STAT: rData = {{PAD_W{1'b0}}, fiqStat};
      REG_RAW_STAT: rData = {{PAD_W{1'b0}}, rawStat};
      REG_ROUTE:    rData = {{PAD_W{1'b0}}, routeReg};
      REG_EN_SET:   rData = {{PAD_W{1'b0}}, enReg};
      REG_SOFT_SET: rData = {{PAD_W{1'b0}}, softReg};
      REG_PROT:     rData = {{(DATA_W-1){1'b0}}, protReg};
      default:      rData = '0;
    endcase
  end

  p_en_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEnSet |=> (((enReg & $past(wBits)) == $past(wBits)) &&
                        ((enReg & $past(enReg)) == $past(enReg))));

  p_en_clr_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEnClr |=> ((enReg & $past(wBits)) == '0));

  p_soft_clr_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSoftClr |=> ((softReg & $past(wBits)) == '0));

  p_route_disjoint_r4: assert property (@(posedge clk) disable iff (!rstN)
    ((irqStat & fiqStat) == '0));

  p_irq_needs_enable_r3: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((enReg & ~routeReg) != '0));

  p_fiq_needs_enable_r4: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> ((enReg & routeReg) != '0));

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] hwReq,
  input  logic               busSel,
  input  logic               busWrite,
  input  logic               busUser,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut,
  output logic               fiqOut
);

  busStrobe_t strobe;
  logic       protOn;

  irq_router_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busUser  (busUser),
    .busAddr  (busAddr),
    .protOn   (protOn),
    .strobe   (strobe)
  );

  irq_router_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .hwReq  (hwReq),
    .wData  (busWdata),
    .strobe (strobe),
    .rData  (busRdata),
    .irqOut (irqOut),
    .fiqOut (fiqOut),
    .protOn (protOn)
  );

  p_user_read_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWrite && busUser && protOn) |-> (busRdata == '0));

endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;

  localparam logic [5:0] A_IRQ = 6'h00, A_FIQ = 6'h04, A_RAW = 6'h08,
                         A_RTE = 6'h0C, A_ENS = 6'h10, A_ENC = 6'h14,
                         A_SWS = 6'h18, A_SWC = 6'h1C, A_PRT = 6'h20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] hwReq = '0;
  logic        busSel = 1'b0, busWrite = 1'b0, busUser = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, fiqOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_router dut (
    .clk(clk), .rstN(rstN), .hwReq(hwReq), .busSel(busSel),
    .busWrite(busWrite), .busUser(busUser), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input bit u);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; busUser = u;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busUser = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input bit u, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a; busUser = u;
    #5 d = busRdata;
    busSel = 1'b0; busUser = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [5:0] a, input bit u, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, u, v);
    chk(req, v, exp);
  endtask

  // program state through the bus, then compare every status view
  task automatic applyAndCheck(input logic [31:0] hw, input logic [31:0] sw,
                               input logic [31:0] en, input logic [31:0] rte);
    logic [31:0] raw, irqE, fiqE;
    wr(A_ENC, 32'hFFFF_FFFF, 1'b0);
    wr(A_ENS, en, 1'b0);
    wr(A_SWC, 32'hFFFF_FFFF, 1'b0);
    wr(A_SWS, sw, 1'b0);
    wr(A_RTE, rte, 1'b0);
    hwReq = hw;
    raw  = hw | sw;
    irqE = raw & en & ~rte;
    fiqE = raw & en & rte;
    rdChk("R2 raw", A_RAW, 1'b0, raw);
    rdChk("R3 irq status", A_IRQ, 1'b0, irqE);
    rdChk("R4 fiq status", A_FIQ, 1'b0, fiqE);
    chk("R3 irqOut", {31'd0, irqOut}, {31'd0, |irqE});
    chk("R4 fiqOut", {31'd0, fiqOut}, {31'd0, |fiqE});
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdChk("R1 irq", A_IRQ, 1'b0, 0);
    rdChk("R1 fiq", A_FIQ, 1'b0, 0);
    rdChk("R1 raw", A_RAW, 1'b0, 0);
    rdChk("R1 route", A_RTE, 1'b0, 0);
    rdChk("R1 enable", A_ENS, 1'b0, 0);
    rdChk("R1 soft", A_SWS, 1'b0, 0);
    rdChk("R1 prot", A_PRT, 1'b0, 0);
    chk("R1 irqOut", {31'd0, irqOut}, 0);
    chk("R1 fiqOut", {31'd0, fiqOut}, 0);

    // exhaustive per-source sweep: hw, soft, enable, route
    for (int s = 0; s < 32; s++) begin
      for (int c = 0; c < 16; c++) begin
        logic [31:0] b;
        b = 32'd1 << s;
        applyAndCheck(c[0] ? b : 0, c[1] ? b : 0, c[2] ? b : 0, c[3] ? b : 0);
      end
    end

    // dense multi-bit patterns
    for (int k = 0; k < 8; k++) begin
      logic [31:0] h, w, e, r;
      h = 32'h9E37_79B9 * (k + 1);
      w = 32'h85EB_CA6B * (k + 3);
      e = 32'hC2B2_AE35 * (k + 5);
      r = 32'h27D4_EB2F * (k + 7);
      applyAndCheck(h, w, e, r);
    end
    hwReq = '0;

    // R5 enable accumulation, R6 selective clear
    wr(A_ENC, 32'hFFFF_FFFF, 1'b0);
    wr(A_ENS, 32'h0000_00F0, 1'b0);
    wr(A_ENS, 32'h0F00_0003, 1'b0);
    rdChk("R5 enable OR", A_ENS, 1'b0, 32'h0F00_00F3);
    wr(A_ENC, 32'h0100_0031, 1'b0);
    rdChk("R6 enable clear", A_ENS, 1'b0, 32'h0E00_00C2);
    rdChk("R6 clear reads zero", A_ENC, 1'b0, 0);

    // R7 software set/clear
    wr(A_SWC, 32'hFFFF_FFFF, 1'b0);
    wr(A_SWS, 32'hA000_0005, 1'b0);
    wr(A_SWS, 32'h0000_0300, 1'b0);
    rdChk("R7 soft OR", A_SWS, 1'b0, 32'hA000_0305);
    wr(A_SWC, 32'h2000_0101, 1'b0);
    rdChk("R7 soft clear", A_SWS, 1'b0, 32'h8000_0204);
    rdChk("R7 clear reads zero", A_SWC, 1'b0, 0);

    // R8 route read/write
    wr(A_RTE, 32'h5A5A_C3C3, 1'b0);
    rdChk("R8 route", A_RTE, 1'b0, 32'h5A5A_C3C3);

    // R9 protection bit only
    wr(A_PRT, 32'hFFFF_FFFE, 1'b0);
    rdChk("R9 prot bit0 clear", A_PRT, 1'b0, 0);

    // R10 user access with protection off works
    wr(A_RTE, 32'h0000_1111, 1'b1);
    rdChk("R10 user unprotected", A_RTE, 1'b1, 32'h0000_1111);
    wr(A_PRT, 32'hFFFF_FFFF, 1'b0);
    rdChk("R9 prot set", A_PRT, 1'b0, 32'h1);
    // user blocked on every writable register
    wr(A_RTE, 32'hFFFF_FFFF, 1'b1);
    wr(A_ENS, 32'hFFFF_FFFF, 1'b1);
    wr(A_SWC, 32'hFFFF_FFFF, 1'b1);
    wr(A_PRT, 32'h0, 1'b1);
    rdChk("R10 user read zero", A_RTE, 1'b1, 0);
    rdChk("R10 user read prot zero", A_PRT, 1'b1, 0);
    rdChk("R10 route kept", A_RTE, 1'b0, 32'h0000_1111);
    rdChk("R10 enable kept", A_ENS, 1'b0, 32'h0E00_00C2);
    rdChk("R10 soft kept", A_SWS, 1'b0, 32'h8000_0204);
    rdChk("R10 prot kept", A_PRT, 1'b0, 32'h1);
    // privileged still works
    wr(A_RTE, 32'h0000_2222, 1'b0);
    rdChk("R10 privileged write", A_RTE, 1'b0, 32'h0000_2222);
    wr(A_PRT, 32'h0, 1'b0);
    rdChk("R10 prot off", A_PRT, 1'b1, 0);

    // R11 unmapped offsets and ignored low address bits
    for (int a = 9; a < 16; a++) begin
      wr(6'(a * 4), 32'hFFFF_FFFF, 1'b0);
      rdChk("R11 unmapped read", 6'(a * 4), 1'b0, 0);
    end
    rdChk("R11 route unchanged", A_RTE, 1'b0, 32'h0000_2222);
    rdChk("R11 enable unchanged", A_ENS, 1'b0, 32'h0E00_00C2);
    rdChk("R11 soft unchanged", A_SWS, 1'b0, 32'h8000_0204);
    rdChk("R11 prot unchanged", A_PRT, 1'b0, 0);
    wr(6'h0F, 32'h0000_7777, 1'b0);
    rdChk("R11 low bits ignored", 6'h0E, 1'b0, 32'h0000_7777);
    rd(A_RAW, 1'b0, v);
    chk("R11 raw after unmapped", v, 32'h8000_0204);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule